// File: doc/BRIEF.md
# Threshold Flag Generator for a Dual-Clock FIFO

This block produces the two threshold flags of a dual-clock FIFO: an active-low almost-empty output and an active-low almost-full output. It takes the write pointer, which belongs to the write clock, and the read pointer, which belongs to the read clock. Both pointers are Gray coded with one wrap bit above the address bits. It also takes two offsets that do not change while the FIFO runs. The block carries each pointer into the other clock domain and works out the fill level in both domains. It compares the stored word count with the empty offset and the free space with the full offset.

A mode bit is captured while master reset is held.

- **Synchronous mode:** each flag is a register clocked only by its own domain. Almost-empty uses the read clock and almost-full uses the write clock.
- **Asynchronous mode:** each flag is built from two toggle flops, one in each clock domain. Almost-empty is asserted by the read side and released by the write side. Almost-full works the other way round. No flop sees two clocks.

A partial reset clears the flag state but keeps the captured mode.

Top module: `pflag_gen`

## Requirements
- R1: While master reset or partial reset is held for at least two edges of each clock, ae_n is 0 and af_n is 1.
- R2: In steady state, ae_n is 0 exactly when the word count is at or below ae_off. The word count is (binary write pointer − binary read pointer) modulo 2^(ADDR_W+1). Each binary pointer is obtained from its Gray code as b[i] = XOR of g[PTR_W-1:i].
- R3: In steady state, af_n is 0 exactly when the free space (2^ADDR_W − word count) is at or below af_off.
- R4: mode_sel is captured only while mrst is 1: 1 selects asynchronous mode and 0 selects synchronous mode. A partial reset leaves the captured mode unchanged.
- R5: In asynchronous mode, ae_n goes low through read-clock edges and returns high through write-clock edges. It therefore releases while the read clock is stopped and asserts while the write clock is stopped.
- R6: In asynchronous mode, af_n goes low through write-clock edges and returns high through read-clock edges.
- R7: In synchronous mode, ae_n changes only on read-clock edges and af_n only on write-clock edges. A flag whose clock is stopped holds its value while the pointers move.
- R8: After a pointer change, both flags reach their steady-state value within eight cycles of each running clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, sampled by both clocks; captures mode_sel |
| prst | input | 1 | Partial reset, active high, sampled by both clocks; keeps the mode |
| mode_sel | input | 1 | Flag timing mode: 1 asynchronous, 0 synchronous |
| wr_gray | input | ADDR_W+1 | Write pointer, Gray coded, write-clock domain |
| rd_gray | input | ADDR_W+1 | Read pointer, Gray coded, read-clock domain |
| ae_off | input | ADDR_W+1 | Almost-empty offset, counted from the empty boundary |
| af_off | input | ADDR_W+1 | Almost-full offset, counted from the full boundary |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
A fault in the Gray-to-binary conversion or in the wrap bit gives a flag of the wrong polarity within a few cycles of the pointer change that exposes it. The bench looks for this at the exact threshold, at completely full, and across a pointer wrap. A toggle pair left out of step gives a flag stuck in one state. A mode that was captured wrongly shows up as a flag that moves, or stays frozen, while the opposite clock is stopped. Stopping one clock at a time therefore shows which domain owns each transition within eight cycles of the running clock.

// File: rtl/pflag_pkg.sv
package pflag_pkg;

    typedef enum logic {
        FLAG_SYNC  = 1'b0,
        FLAG_ASYNC = 1'b1
    } flag_mode_e;

    typedef struct packed {
        logic ae_hit;   // word count at or below empty offset
        logic af_hit;   // free space at or below full offset
    } level_hits_t;

    // A toggle pair signals "flag on" either when its two bits agree or
    // when they differ, chosen so that both bits at zero give the reset state.
    function automatic logic flag_on(logic a, logic b, logic on_when_equal);
        return on_when_equal ? (a == b) : (a != b);
    endfunction

endpackage

// File: rtl/pflag_sync.sv
module pflag_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pflag_level.sv
module pflag_level
    import pflag_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W:0] w_gray,
    input  logic [ADDR_W:0] r_gray,
    input  logic [ADDR_W:0] ae_off,
    input  logic [ADDR_W:0] af_off,
    output level_hits_t     hits
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(1) << ADDR_W;

    logic [PTR_W-1:0] wb, rb, words, room;

    for (genvar i = 0; i < PTR_W; i++) begin : g_g2b
        assign wb[i] = ^w_gray[PTR_W-1:i];
        assign rb[i] = ^r_gray[PTR_W-1:i];
    end

    always_comb begin
        words       = wb - rb;
        room        = DEPTH_V - words;
        hits.ae_hit = (words <= ae_off);
        hits.af_hit = (room <= af_off);
    end
endmodule

// File: rtl/pflag_toggle.sv
module pflag_toggle
    import pflag_pkg::*;
#(
    parameter bit ON_AT_RESET = 1'b1
) (
    input  logic set_clk,
    input  logic set_rst,
    input  logic set_en,
    input  logic set_req,
    input  logic clr_clk,
    input  logic clr_rst,
    input  logic clr_en,
    input  logic clr_req,
    output logic flag_n
);
    logic ts, tc;            // set-side and clear-side toggles
    logic ts_at_c, tc_at_s;  // each toggle seen in the other domain

    pflag_sync #(.W(1)) u_ts2c (.clk(clr_clk), .rst(clr_rst), .d(ts), .q(ts_at_c));
    pflag_sync #(.W(1)) u_tc2s (.clk(set_clk), .rst(set_rst), .d(tc), .q(tc_at_s));

    always_ff @(posedge set_clk) begin
        if (set_rst)
            ts <= 1'b0;
        else if (set_en && set_req && !flag_on(ts, tc_at_s, ON_AT_RESET))
            ts <= ~ts;
    end

    always_ff @(posedge clr_clk) begin
        if (clr_rst)
            tc <= 1'b0;
        else if (clr_en && clr_req && flag_on(ts_at_c, tc, ON_AT_RESET))
            tc <= ~tc;
    end

    assign flag_n = ~flag_on(ts, tc, ON_AT_RESET);

    // R5 for the almost-empty pair, R6 for the almost-full pair.
    p_set_needs_req_r5: assert property (@(posedge set_clk) disable iff (set_rst)
        (!$past(set_rst) && ts != $past(ts)) |-> $past(set_req && set_en))
        else $error("set toggle flipped without a set request");

    p_clr_needs_req_r6: assert property (@(posedge clr_clk) disable iff (clr_rst)
        (!$past(clr_rst) && tc != $past(tc)) |-> $past(clr_req && clr_en))
        else $error("clear toggle flipped without a clear request");
endmodule

// File: rtl/pflag_gen.sv
module pflag_gen
    import pflag_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic            wclk,
    input  logic            rclk,
    input  logic            mrst,
    input  logic            prst,
    input  logic            mode_sel,
    input  logic [ADDR_W:0] wr_gray,
    input  logic [ADDR_W:0] rd_gray,
    input  logic [ADDR_W:0] ae_off,
    input  logic [ADDR_W:0] af_off,
    output logic            ae_n,
    output logic            af_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic        rst_r, rst_w;
    flag_mode_e  mode_r, mode_w;
    logic [PTR_W-1:0] wg_at_r, rg_at_w;
    level_hits_t hits_r, hits_w;
    logic        ae_sync_n, af_sync_n;
    logic        ae_tog_n, af_tog_n;

    assign rst_r = mrst | prst;
    assign rst_w = mrst | prst;

    // Mode captured in each domain only during master reset.
    always_ff @(posedge rclk) if (mrst) mode_r <= flag_mode_e'(mode_sel);
    always_ff @(posedge wclk) if (mrst) mode_w <= flag_mode_e'(mode_sel);

    pflag_sync #(.W(PTR_W)) u_w2r (.clk(rclk), .rst(rst_r), .d(wr_gray), .q(wg_at_r));
    pflag_sync #(.W(PTR_W)) u_r2w (.clk(wclk), .rst(rst_w), .d(rd_gray), .q(rg_at_w));

    pflag_level #(.ADDR_W(ADDR_W)) u_lvl_r (
        .w_gray(wg_at_r), .r_gray(rd_gray), .ae_off(ae_off), .af_off(af_off), .hits(hits_r));
    pflag_level #(.ADDR_W(ADDR_W)) u_lvl_w (
        .w_gray(wr_gray), .r_gray(rg_at_w), .ae_off(ae_off), .af_off(af_off), .hits(hits_w));

    // Synchronous-mode flags: each in its own domain only.
    always_ff @(posedge rclk) begin
        if (rst_r) ae_sync_n <= 1'b0;
        else       ae_sync_n <= ~hits_r.ae_hit;
    end

    always_ff @(posedge wclk) begin
        if (rst_w) af_sync_n <= 1'b1;
        else       af_sync_n <= ~hits_w.af_hit;
    end

    // Asynchronous-mode flags: set in one domain, cleared in the other.
    pflag_toggle #(.ON_AT_RESET(1'b1)) u_ae (
        .set_clk(rclk), .set_rst(rst_r), .set_en(mode_r == FLAG_ASYNC), .set_req(hits_r.ae_hit),
        .clr_clk(wclk), .clr_rst(rst_w), .clr_en(mode_w == FLAG_ASYNC), .clr_req(~hits_w.ae_hit),
        .flag_n(ae_tog_n));

    pflag_toggle #(.ON_AT_RESET(1'b0)) u_af (
        .set_clk(wclk), .set_rst(rst_w), .set_en(mode_w == FLAG_ASYNC), .set_req(hits_w.af_hit),
        .clr_clk(rclk), .clr_rst(rst_r), .clr_en(mode_r == FLAG_ASYNC), .clr_req(~hits_r.af_hit),
        .flag_n(af_tog_n));

    assign ae_n = (mode_r == FLAG_ASYNC) ? ae_tog_n : ae_sync_n;
    assign af_n = (mode_w == FLAG_ASYNC) ? af_tog_n : af_sync_n;

    p_ae_sync_r7: assert property (@(posedge rclk) disable iff (rst_r)
        (!$past(rst_r) && mode_r == FLAG_SYNC) |-> (ae_n == !$past(hits_r.ae_hit)))
        else $error("synchronous almost-empty does not follow read-side level");

    p_af_sync_r7: assert property (@(posedge wclk) disable iff (rst_w)
        (!$past(rst_w) && mode_w == FLAG_SYNC) |-> (af_n == !$past(hits_w.af_hit)))
        else $error("synchronous almost-full does not follow write-side level");
endmodule

// File: tb/sim_pflag_gen.sv
module sim_pflag_gen;
    localparam int CLK_PERIOD = 10;
    localparam int RCLK_HALF  = 6;
    localparam int ADDR_W     = 4;
    localparam int PTR_W      = ADDR_W + 1;

    typedef struct packed {
        logic [4:0] w;
        logic [4:0] r;
        logic [4:0] aeo;
        logic [4:0] afo;
        logic       eae;
        logic       eaf;
    } vec_t;

    // Steady-state vectors: pointers (binary), offsets, expected ae_n, af_n.
    localparam vec_t VEC [12] = '{
        '{5'd0,  5'd0,  5'd2, 5'd2, 1'b0, 1'b1},  // empty
        '{5'd3,  5'd0,  5'd2, 5'd2, 1'b1, 1'b1},  // count 3 above offset
        '{5'd2,  5'd0,  5'd2, 5'd2, 1'b0, 1'b1},  // count equals ae offset
        '{5'd14, 5'd0,  5'd2, 5'd2, 1'b1, 1'b0},  // free equals af offset
        '{5'd13, 5'd0,  5'd2, 5'd2, 1'b1, 1'b1},  // free 3
        '{5'd16, 5'd0,  5'd2, 5'd2, 1'b1, 1'b0},  // full
        '{5'd20, 5'd5,  5'd2, 5'd2, 1'b1, 1'b0},  // count 15
        '{5'd20, 5'd20, 5'd2, 5'd2, 1'b0, 1'b1},  // empty again
        '{5'd25, 5'd20, 5'd5, 5'd0, 1'b0, 1'b1},  // count 5 at offset 5
        '{5'd26, 5'd20, 5'd5, 5'd0, 1'b1, 1'b1},  // count 6
        '{5'd4,  5'd20, 5'd5, 5'd0, 1'b1, 1'b0},  // wrapped, full, offset 0
        '{5'd3,  5'd20, 5'd5, 5'd0, 1'b1, 1'b1}   // wrapped, free 1
    };

    logic wclk = 1'b0, rclk = 1'b0;
    logic wclk_en = 1'b1, rclk_en = 1'b1;
    logic mrst = 1'b1, prst = 1'b0, mode_sel = 1'b0;
    logic [PTR_W-1:0] wp = '0, rp = '0, ae_off = 5'd2, af_off = 5'd2;
    logic [PTR_W-1:0] wr_gray, rd_gray;
    logic ae_n, af_n;
    int checks = 0, errors = 0;

    assign wr_gray = wp ^ (wp >> 1);
    assign rd_gray = rp ^ (rp >> 1);

    always #(CLK_PERIOD/2) if (wclk_en) wclk = ~wclk;
    initial begin
        #1;
        forever #(RCLK_HALF) if (rclk_en) rclk = ~rclk;
    end

    pflag_gen #(.ADDR_W(ADDR_W)) u0 (
        .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
        .wr_gray(wr_gray), .rd_gray(rd_gray), .ae_off(ae_off), .af_off(af_off),
        .ae_n(ae_n), .af_n(af_n));

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge wclk);
    endtask

    task automatic settle();
        if (wclk_en) tick(10);
        else #(CLK_PERIOD*10);
    endtask

    task automatic pulse_reset(input logic master, input logic msel, input string tag);
        @(negedge wclk);
        mode_sel = msel;
        if (master) mrst = 1'b1; else prst = 1'b1;
        tick(6);
        check({tag, " ae_n in reset"}, ae_n, 1'b0);
        check({tag, " af_n in reset"}, af_n, 1'b1);
        mrst = 1'b0;
        prst = 1'b0;
    endtask

    task automatic set_ptrs(input logic [4:0] w, input logic [4:0] r);
        if (wclk_en) @(negedge wclk); else #1;
        wp = w;
        rp = r;
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: initial master reset, synchronous mode
        tick(6);
        check("R1 ae_n in first reset", ae_n, 1'b0);
        check("R1 af_n in first reset", af_n, 1'b1);
        mrst = 1'b0;

        // R2 R3 R8: steady-state table walk
        foreach (VEC[k]) begin
            @(negedge wclk);
            wp = VEC[k].w; rp = VEC[k].r;
            ae_off = VEC[k].aeo; af_off = VEC[k].afo;
            settle();
            check($sformatf("R2 vec %0d ae_n", k), ae_n, VEC[k].eae);
            check($sformatf("R3 vec %0d af_n", k), af_n, VEC[k].eaf);
        end

        // R1 with partial reset from a state where both flags differ from reset
        ae_off = 5'd2; af_off = 5'd2;
        set_ptrs(5'd14, 5'd0);
        settle();
        check("R3 af low before prst", af_n, 1'b0);
        pulse_reset(1'b0, 1'b0, "R1 prst");
        settle();
        check("R2 ae_n re-evaluated after prst", ae_n, 1'b1);
        check("R3 af_n re-evaluated after prst", af_n, 1'b0);

        // R7: synchronous mode, stopped clock freezes its flag
        set_ptrs(5'd0, 5'd0);
        settle();
        @(negedge wclk); rclk_en = 1'b0;
        set_ptrs(5'd5, 5'd0);
        settle();
        check("R7 sync ae_n held with read clock stopped", ae_n, 1'b0);
        rclk_en = 1'b1;
        settle();
        check("R7 sync ae_n updates on read clock", ae_n, 1'b1);
        set_ptrs(5'd14, 5'd0);
        settle();
        check("R7 sync af_n low", af_n, 1'b0);
        wclk_en = 1'b0;
        #1; rp = 5'd3;
        settle();
        check("R7 sync af_n held with write clock stopped", af_n, 1'b0);
        wclk_en = 1'b1;
        settle();
        check("R7 sync af_n updates on write clock", af_n, 1'b1);

        // Asynchronous mode via master reset
        set_ptrs(5'd0, 5'd0);
        pulse_reset(1'b1, 1'b1, "R1 mrst async");
        @(negedge wclk); mode_sel = 1'b0;   // R4: ignored outside master reset
        settle();
        @(negedge wclk); rclk_en = 1'b0;
        set_ptrs(5'd5, 5'd0);
        settle();
        check("R5 async ae_n released by write clock", ae_n, 1'b1);
        rclk_en = 1'b1;
        settle();
        wclk_en = 1'b0;
        #1; rp = 5'd4;
        settle();
        check("R5 async ae_n asserted by read clock", ae_n, 1'b0);
        wclk_en = 1'b1;
        settle();
        @(negedge wclk); rclk_en = 1'b0;
        set_ptrs(5'd18, 5'd4);
        settle();
        check("R6 async af_n asserted by write clock", af_n, 1'b0);
        rclk_en = 1'b1;
        settle();
        wclk_en = 1'b0;
        #1; rp = 5'd6;
        settle();
        check("R6 async af_n released by read clock", af_n, 1'b1);
        wclk_en = 1'b1;
        settle();

        // R4: partial reset keeps asynchronous mode
        pulse_reset(1'b0, 1'b0, "R1 prst async");
        set_ptrs(5'd18, 5'd18);
        settle();
        @(negedge wclk); rclk_en = 1'b0;
        set_ptrs(5'd24, 5'd18);
        settle();
        check("R4 mode kept across prst", ae_n, 1'b1);
        rclk_en = 1'b1;
        settle();

        // R4: master reset takes the new mode
        pulse_reset(1'b1, 1'b0, "R1 mrst sync");
        set_ptrs(5'd24, 5'd24);
        settle();
        @(negedge wclk); rclk_en = 1'b0;
        set_ptrs(5'd30, 5'd24);
        settle();
        check("R4 sync mode taken at mrst", ae_n, 1'b0);
        rclk_en = 1'b1;
        settle();
        check("R8 ae_n settles after restart", ae_n, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule